// File: doc/BRIEF.md
# ALU Status Flag Generator

This block sits beside an integer ALU and turns an 8-bit or 16-bit add, subtract or bitwise result into the six status flags of a 16-bit flag word. The same word also holds three control flags that software sets and clears directly. The two operands, the operation code and a byte/word select produce the result combinationally in the same cycle. The flag word is a register. It loads the new status flags at a clock edge only when the write strobe is high.

The control flags (trap, interrupt enable, direction) have their own set and clear vectors. Arithmetic never touches them. In byte mode only the low 8 bits of each operand count, and the upper result byte reads as zero. Carry, sign, zero and overflow all follow the selected width. Parity always looks only at the low result byte.

Top module: `alu_flag_unit`

## Requirements
- R1: The carry flag (word bit 0) is set when an add carries out of the top bit of the selected width (bit 7 for byte, bit 15 for word), or when a subtract (a minus b) needs a borrow into that bit. Otherwise it is cleared.
- R2: The auxiliary flag (word bit 4) is set when an add carries from bit 3 into bit 4, or when a subtract borrows across that boundary. Otherwise it is cleared.
- R3: The overflow flag (word bit 11) is set when the signed two's-complement result of an add or subtract does not fit the selected width.
- R4: The zero flag (word bit 6) is set when all result bits within the selected width are zero. The sign flag (word bit 7) copies the top result bit of that width. In byte mode, result bits 15:8 are zero.
- R5: The parity flag (word bit 2) is set when result bits 7:0 hold an even number of ones, in both widths.
- R6: op_sel codes are 00 add, 01 subtract, 10 AND, 11 XOR. For the two logic codes, a write clears carry and overflow, updates zero, sign and parity, and leaves the auxiliary flag unchanged.
- R7: Status flags change only at a rising clock edge where flag_we is 1. With flag_we at 0, they keep their values whatever the operands are.
- R8: Control-vector bit 0 is trap (word bit 8), bit 1 is interrupt enable (word bit 9) and bit 2 is direction (word bit 10). At each clock edge a set bit forces its flag to 1, otherwise a clear bit forces it to 0, independent of flag_we. Arithmetic never alters these flags.
- R9: Flag word bit 1 always reads 1. Bits 3, 5 and 15:12 always read 0.
- R10: While rst_n is low, every defined flag is cleared, so the flag word reads 0x0002.
- R11: result is a combinational function of the present operands, op_sel and wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| opnd_a | input | 16 | First operand (minuend for subtract) |
| opnd_b | input | 16 | Second operand |
| op_sel | input | 2 | 00 add, 01 sub, 10 AND, 11 XOR |
| wide | input | 1 | 1 = 16-bit operation, 0 = 8-bit |
| flag_we | input | 1 | Load status flags at this clock edge |
| ctl_set | input | 3 | Set trap / interrupt enable / direction |
| ctl_clr | input | 3 | Clear trap / interrupt enable / direction |
| result | output | 16 | Operation result, upper byte zero in byte mode |
| flags | output | 16 | Packed flag word |

## Verification
The result is due in the same cycle as its inputs. The flag word shows the effect of those inputs one rising edge later. The driver applies a new stimulus at each falling edge and queues the matching result and post-edge flag word. The monitor samples a quarter period after the next rising edge, while the inputs are still held. At that point the combinational result still belongs to the queued stimulus and the flag register has taken exactly one update.

// File: rtl/afg_pkg.sv
package afg_pkg;
    localparam int WORD_W = 16;
    localparam int BYTE_W = 8;
    localparam int NIB_W  = 4;
    localparam int CTL_N  = 3;

    localparam int BIT_CF  = 0;
    localparam int BIT_ONE = 1;
    localparam int BIT_PF  = 2;
    localparam int BIT_AF  = 4;
    localparam int BIT_ZF  = 6;
    localparam int BIT_SF  = 7;
    localparam int BIT_CTL = 8;
    localparam int BIT_OF  = 11;

    typedef enum logic [1:0] {
        OP_ADD = 2'b00,
        OP_SUB = 2'b01,
        OP_AND = 2'b10,
        OP_XOR = 2'b11
    } afg_op_e;

    typedef struct packed {
        logic [CTL_N-1:0] ctl;
        logic             of;
        logic             sf;
        logic             zf;
        logic             af;
        logic             pf;
        logic             cf;
    } afg_flags_t;
endpackage

// File: rtl/afg_arith.sv
module afg_arith
    import afg_pkg::*;
#(
    parameter int W    = WORD_W,
    parameter int HALF = BYTE_W,
    parameter int NIB  = NIB_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  afg_op_e      op,
    input  logic         wide,
    output logic [W-1:0] res,
    output logic         carry,
    output logic         aux,
    output logic         ovf
);
    localparam logic [W-1:0] LOW_MASK = {{(W-HALF){1'b0}}, {HALF{1'b1}}};

    logic [W-1:0]   mask;
    logic [W-1:0]   am;
    logic [W-1:0]   bm;
    logic [W:0]     ext_sum;
    logic [W:0]     ext_dif;
    logic [NIB:0]   nib_sum;
    logic [NIB:0]   nib_dif;
    logic [W:0]     raw;
    logic           a_top;
    logic           b_top;
    logic           r_top;

    always_comb begin
        mask    = wide ? '1 : LOW_MASK;
        am      = a & mask;
        bm      = b & mask;
        ext_sum = {1'b0, am} + {1'b0, bm};
        ext_dif = {1'b0, am} - {1'b0, bm};
        nib_sum = {1'b0, a[NIB-1:0]} + {1'b0, b[NIB-1:0]};
        nib_dif = {1'b0, a[NIB-1:0]} - {1'b0, b[NIB-1:0]};
        raw     = '0;
        carry   = 1'b0;
        aux     = 1'b0;
        unique case (op)
            OP_ADD: begin
                raw   = ext_sum;
                carry = wide ? ext_sum[W] : ext_sum[HALF];
                aux   = nib_sum[NIB];
            end
            OP_SUB: begin
                raw   = ext_dif;
                carry = wide ? ext_dif[W] : ext_dif[HALF];
                aux   = nib_dif[NIB];
            end
            OP_AND: raw = {1'b0, am & bm};
            OP_XOR: raw = {1'b0, am ^ bm};
            default: raw = '0;
        endcase
        res   = raw[W-1:0] & mask;
        a_top = wide ? am[W-1]  : am[HALF-1];
        b_top = wide ? bm[W-1]  : bm[HALF-1];
        r_top = wide ? res[W-1] : res[HALF-1];
        ovf   = 1'b0;
        if (op == OP_ADD) begin
            ovf = (a_top == b_top) && (r_top != a_top);
        end else if (op == OP_SUB) begin
            ovf = (a_top != b_top) && (r_top != a_top);
        end
    end
endmodule

// File: rtl/afg_status.sv
module afg_status
    import afg_pkg::*;
#(
    parameter int W    = WORD_W,
    parameter int HALF = BYTE_W
) (
    input  logic [W-1:0] res,
    input  logic         wide,
    output logic         zero,
    output logic         sign,
    output logic         parity
);
    always_comb begin
        zero   = (res == '0);
        sign   = wide ? res[W-1] : res[HALF-1];
        parity = ~(^res[HALF-1:0]);
    end
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
    import afg_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     opnd_a,
    input  logic [W-1:0]     opnd_b,
    input  logic [1:0]       op_sel,
    input  logic             wide,
    input  logic             flag_we,
    input  logic [CTL_N-1:0] ctl_set,
    input  logic [CTL_N-1:0] ctl_clr,
    output logic [W-1:0]     result,
    output logic [W-1:0]     flags
);
    afg_op_e    op;
    logic       carry;
    logic       aux;
    logic       ovf;
    logic       zero;
    logic       sign;
    logic       parity;
    afg_flags_t flags_d;
    afg_flags_t flags_q;

    assign op = afg_op_e'(op_sel);

    afg_arith #(.W(W), .HALF(BYTE_W), .NIB(NIB_W)) u_arith (
        .a(opnd_a), .b(opnd_b), .op(op), .wide(wide),
        .res(result), .carry(carry), .aux(aux), .ovf(ovf)
    );

    afg_status #(.W(W), .HALF(BYTE_W)) u_status (
        .res(result), .wide(wide),
        .zero(zero), .sign(sign), .parity(parity)
    );

    always_comb begin
        flags_d = flags_q;
        if (flag_we) begin
            flags_d.cf = carry;
            flags_d.of = ovf;
            flags_d.zf = zero;
            flags_d.sf = sign;
            flags_d.pf = parity;
            if (!op_sel[1]) begin
                flags_d.af = aux;
            end
        end
        for (int k = 0; k < CTL_N; k++) begin
            if (ctl_set[k]) begin
                flags_d.ctl[k] = 1'b1;
            end else if (ctl_clr[k]) begin
                flags_d.ctl[k] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_d;
        end
    end

    always_comb begin
        flags = '0;
        flags[BIT_ONE] = 1'b1;
        flags[BIT_CF]  = flags_q.cf;
        flags[BIT_PF]  = flags_q.pf;
        flags[BIT_AF]  = flags_q.af;
        flags[BIT_ZF]  = flags_q.zf;
        flags[BIT_SF]  = flags_q.sf;
        flags[BIT_OF]  = flags_q.of;
        for (int k = 0; k < CTL_N; k++) begin
            flags[BIT_CTL+k] = flags_q.ctl[k];
        end
    end

    p_byte_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !wide |-> (result[W-1:BYTE_W] == '0));

    p_zero_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we |=> (flags[BIT_ZF] == ($past(result) == '0)));

    p_parity_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we |=> (flags[BIT_PF] == ~(^$past(result[BYTE_W-1:0]))));

    p_logic_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we && op_sel[1]) |=> (!flags[BIT_CF] && !flags[BIT_OF] && $stable(flags[BIT_AF])));

    p_status_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_we |=> ($stable(flags[BIT_SF:0]) && $stable(flags[BIT_OF])));

    p_ctl_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_set == '0 && ctl_clr == '0) |=> $stable(flags[BIT_CTL+CTL_N-1:BIT_CTL]));

    p_ctl_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_set[0] |=> flags[BIT_CTL]);

    p_fixed_bits_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flags[BIT_ONE] && !flags[3] && !flags[5] && (flags[W-1:BIT_OF+1] == '0));
endmodule

// File: tb/sim_alu_flag_unit.sv
module sim_alu_flag_unit;
    localparam int CLK_P = 10;

    typedef struct packed {
        logic [15:0] r;
        logic [15:0] f;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] opnd_a = '0;
    logic [15:0] opnd_b = '0;
    logic [1:0]  op_sel = '0;
    logic        wide = 1'b0;
    logic        flag_we = 1'b0;
    logic [2:0]  ctl_set = '0;
    logic [2:0]  ctl_clr = '0;
    logic [15:0] result;
    logic [15:0] flags;

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    exp_t  exp_q[$];
    string tag_q[$];
    logic [15:0] mdl = 16'h0002;

    alu_flag_unit u0 (
        .clk(clk), .rst_n(rst_n), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .op_sel(op_sel), .wide(wide), .flag_we(flag_we),
        .ctl_set(ctl_set), .ctl_clr(ctl_clr),
        .result(result), .flags(flags)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(string req, string tag, logic [15:0] act, logic [15:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s [%s] actual=%h expected=%h", req, tag, act, expv);
        end
    endtask

    function automatic int sgn(int v, bit w);
        if (w) return (v >= 32768) ? v - 65536 : v;
        return (v >= 128) ? v - 256 : v;
    endfunction

    task automatic step(logic [15:0] a, logic [15:0] b, logic [1:0] op, bit w,
                        bit we, logic [2:0] s, logic [2:0] c, string tag);
        int mask, am, bm, r, sr, ones;
        bit cf, af, of;
        exp_t e;
        @(negedge clk);
        opnd_a = a; opnd_b = b; op_sel = op; wide = w;
        flag_we = we; ctl_set = s; ctl_clr = c;
        mask = w ? 65535 : 255;
        am = int'(a) & mask;
        bm = int'(b) & mask;
        cf = 0; af = 0; of = 0; sr = 0;
        case (op)
            2'b00: begin
                r = am + bm; cf = (r > mask);
                af = ((am % 16) + (bm % 16)) > 15;
                sr = sgn(am, w) + sgn(bm, w);
            end
            2'b01: begin
                r = am - bm; cf = (am < bm);
                af = (am % 16) < (bm % 16);
                sr = sgn(am, w) - sgn(bm, w);
            end
            2'b10: r = am & bm;
            default: r = am ^ bm;
        endcase
        r = r & mask;
        if (op[1] == 1'b0)
            of = w ? (sr > 32767 || sr < -32768) : (sr > 127 || sr < -128);
        if (we) begin
            ones = 0;
            for (int i = 0; i < 8; i++) ones += (r >> i) & 1;
            mdl[0]  = cf;
            mdl[11] = of;
            mdl[2]  = (ones % 2) == 0;
            mdl[6]  = (r == 0);
            mdl[7]  = w ? r[15] : r[7];
            if (op[1] == 1'b0) mdl[4] = af;
        end
        for (int k = 0; k < 3; k++) begin
            if (s[k]) mdl[8+k] = 1'b1;
            else if (c[k]) mdl[8+k] = 1'b0;
        end
        e.r = r[15:0];
        e.f = mdl;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    initial begin : monitor
        exp_t  e;
        string t;
        forever begin
            @(posedge clk);
            #(CLK_P/4);
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk("R11", t, result, e.r);
                chk("R1", t, {15'd0, flags[0]}, {15'd0, e.f[0]});
                chk("R2", t, {15'd0, flags[4]}, {15'd0, e.f[4]});
                chk("R3", t, {15'd0, flags[11]}, {15'd0, e.f[11]});
                chk("R4", t, {14'd0, flags[7:6]}, {14'd0, e.f[7:6]});
                chk("R5", t, {15'd0, flags[2]}, {15'd0, e.f[2]});
                chk("R8", t, {13'd0, flags[10:8]}, {13'd0, e.f[10:8]});
                chk("R9", t, flags & 16'hF02A, 16'h0002);
            end
        end
    end

    initial begin : watchdog
        #(CLK_P * 100000);
        if (!done) begin
            errors++;
            $display("FAIL R7 watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : driver
        // R10: control requests during reset are ignored
        ctl_set = 3'b111;
        flag_we = 1'b1;
        repeat (3) @(posedge clk);
        #(CLK_P/4);
        chk("R10", "in reset", flags, 16'h0002);
        @(negedge clk);
        ctl_set = '0; flag_we = 1'b0;
        rst_n = 1'b1;
        #(CLK_P/4);
        chk("R10", "after reset", flags, 16'h0002);

        step(16'h007F, 16'h0001, 2'b00, 0, 1, 3'b000, 3'b000, "R3 byte add overflow");
        step(16'h00FF, 16'h0001, 2'b00, 0, 1, 3'b000, 3'b000, "R1 byte carry to zero");
        step(16'hFFFF, 16'h0001, 2'b00, 1, 1, 3'b000, 3'b000, "R1 word carry");
        step(16'h7FFF, 16'h0001, 2'b00, 1, 1, 3'b000, 3'b000, "R3 word overflow");
        step(16'h0000, 16'h0001, 2'b01, 0, 1, 3'b000, 3'b000, "R1 byte borrow");
        step(16'h8000, 16'h0001, 2'b01, 1, 1, 3'b000, 3'b000, "R3 word sub overflow");
        step(16'hAB12, 16'hCD34, 2'b00, 0, 1, 3'b000, 3'b000, "R4 byte ignores upper");
        step(16'h0010, 16'h0001, 2'b01, 1, 1, 3'b000, 3'b000, "R2 nibble borrow");
        step(16'h1234, 16'h1234, 2'b01, 1, 1, 3'b000, 3'b000, "R4 word zero");
        step(16'h000F, 16'h0001, 2'b00, 1, 1, 3'b000, 3'b000, "R2 nibble carry set");
        step(16'hF0F0, 16'h0FF0, 2'b10, 1, 1, 3'b000, 3'b000, "R6 AND keeps aux");
        step(16'hFFFF, 16'hFFFF, 2'b11, 1, 1, 3'b000, 3'b000, "R6 XOR zero");
        step(16'hFFFF, 16'h0001, 2'b00, 1, 0, 3'b000, 3'b000, "R7 hold without strobe");
        step(16'h0080, 16'h0080, 2'b00, 0, 0, 3'b000, 3'b000, "R7 hold byte");
        step(16'h0000, 16'h0000, 2'b00, 1, 0, 3'b111, 3'b000, "R8 set all");
        step(16'h7FFF, 16'h7FFF, 2'b00, 1, 1, 3'b000, 3'b000, "R8 arith keeps control");
        step(16'h0000, 16'h0000, 2'b00, 1, 0, 3'b000, 3'b010, "R8 clear interrupt");
        step(16'h0000, 16'h0000, 2'b00, 1, 0, 3'b101, 3'b101, "R8 set wins");
        step(16'h0000, 16'h0000, 2'b00, 1, 0, 3'b000, 3'b111, "R8 clear all");
        step(16'h0003, 16'h0000, 2'b11, 0, 1, 3'b000, 3'b000, "R5 parity even");
        step(16'h0107, 16'h0000, 2'b11, 1, 1, 3'b000, 3'b000, "R5 parity low byte only");
        for (int n = 0; n < 300; n++) begin
            step(16'($urandom), 16'($urandom), 2'($urandom), 1'($urandom),
                 1'($urandom), 3'($urandom), 3'($urandom), "R9 random mix");
        end
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule